// File: doc/BRIEF.md
# Watchdog Timer with Guarded Disable

This block is a software watchdog. It counts down on a dedicated slow tick (nominally 1 MHz) and raises a one-cycle reset request when the count runs out while it is enabled. Software keeps the system alive by pulsing a restart strobe before the period expires. Each restart reloads the full period. The period is a power of two selected by a 3-bit field in an 8-bit control register.

The control register cannot turn the watchdog off with a single write. Clearing the enable bit needs an unlock step first. Software writes the turn-off bit and the enable bit together, which opens a short window. A write that clears enable inside that window disables the timer. Hardware drops the turn-off bit by itself once the window has closed.

Top module: `wdog_guard`

## Requirements
- R1: `rd_data` always reads {3'b000, turn-off (bit 4), enable (bit 3), prescale (bits 2:0)}. Bits 7:5 read zero whatever was written there. After reset the register reads 8'h00.
- R2: Any write sets bits 2:0 to the written prescale. A write with bit 3 = 1 sets the enable bit.
- R3: A write with bit 3 = 0 while no turn-off window is open leaves the enable bit unchanged.
- R4: A write with bits 4 and 3 both 1 opens the turn-off window. Bit 4 then reads 1 in the four cycles after that write, and hardware clears it to 0 in the fifth.
- R5: A write with bit 3 = 0 in any of the four cycles after the unlocking write clears enable. The same write one cycle later is ignored, as R3 states.
- R6: A write with bit 4 = 1 and bit 3 = 0 does not open a window, so bit 4 keeps reading 0.
- R7: While enabled, the period is 2^(BASE_LOG2+prescale) ticks. BASE_LOG2 defaults to 14, giving 16K to 2048K ticks. `rst_req` is high for exactly the one cycle after the edge that takes the final tick, and counting then restarts from the full period.
- R8: `kick` reloads the full period. A `kick` in the same cycle as the final tick wins, and no request is raised.
- R9: Setting enable from 0, or changing the prescale while enabled, reloads the count with the new period at that write.
- R10: While disabled, `rst_req` stays low and ticks have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable pulse from the slow timebase |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| kick | input | 1 | Restart strobe, reloads the period |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Two events can land in the same cycle: a restart strobe and the tick that would end the period. The bench runs the count down to one tick remaining. It then drives `kick` and `tick` together and expects `rst_req` to stay low, followed by a full fresh period. A second collision is a register write that reloads the period while a tick arrives; the reload must win. Random traffic keeps producing both collisions. A bench reference model judges every cycle of `rd_data` and `rst_req`.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int CTRL_W  = 8;
    localparam int PS_W    = 3;
    localparam int WIN_CYC = 4;
    localparam int WIN_W   = 3;
    localparam int BIT_TOE = 4;
    localparam int BIT_EN  = 3;

    typedef struct packed {
        logic             en;
        logic [WIN_W-1:0] win;
        logic [PS_W-1:0]  ps;
    } ctrl_st_t;
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic              en_o,
    output logic [PS_W-1:0]   ps_nx_o,
    output logic              load_o,
    output logic [CTRL_W-1:0] rd_data_o
);
    ctrl_st_t st_d, st_q;
    logic     unlock;
    logic     win_open;

    // next-state computation
    always_comb begin
        st_d     = st_q;
        unlock   = wr_en & wr_data[BIT_TOE] & wr_data[BIT_EN];
        win_open = (st_q.win != '0);
        if (unlock)
            st_d.win = WIN_W'(WIN_CYC);
        else if (win_open)
            st_d.win = st_q.win - 1'b1;
        if (wr_en) begin
            st_d.ps = wr_data[PS_W-1:0];
            if (wr_data[BIT_EN])
                st_d.en = 1'b1;
            else if (win_open)
                st_d.en = 1'b0;
        end
        load_o = wr_en & ((wr_data[BIT_EN] & ~st_q.en) |
                          (st_q.en & (st_d.ps != st_q.ps)));
        ps_nx_o = st_d.ps;
        en_o    = st_q.en;
        rd_data_o                = '0;
        rd_data_o[BIT_TOE]       = win_open;
        rd_data_o[BIT_EN]        = st_q.en;
        rd_data_o[PS_W-1:0]      = st_q.ps;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[BIT_EN]) |=> st_q.en);

    p_en_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[BIT_EN] && st_q.win == '0 && st_q.en) |=> st_q.en);

    p_toe_expire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.win == WIN_W'(1) && !(wr_en && wr_data[BIT_TOE] && wr_data[BIT_EN]))
        |=> (rd_data_o[BIT_TOE] == 1'b0));

    p_disable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[BIT_EN] && st_q.win != '0) |=> !st_q.en);

    p_no_unlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[BIT_TOE] && !wr_data[BIT_EN] && st_q.win == '0)
        |=> (rd_data_o[BIT_TOE] == 1'b0));
endmodule

// File: rtl/wdog_period.sv
module wdog_period #(
    parameter int CW   = 22,
    parameter int BASE = 14,
    parameter int PS_W = 3
) (
    input  logic [PS_W-1:0] ps_i,
    output logic [CW-1:0]   period_o
);
    localparam int N = 1 << PS_W;

    logic [CW-1:0] cand [N];

    for (genvar i = 0; i < N; i++) begin : g_sel
        localparam logic [CW-1:0] PER = CW'(1) << (BASE + i);
        assign cand[i] = (ps_i == PS_W'(i)) ? PER : '0;
    end

    always_comb begin
        period_o = '0;
        for (int i = 0; i < N; i++)
            period_o = period_o | cand[i];
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          load_i,
    input  logic          kick_i,
    input  logic          tick_i,
    input  logic [CW-1:0] period_i,
    output logic          rst_req_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          req;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (!en_i || load_i || kick_i) begin
            st_d.cnt = period_i;
        end else if (tick_i) begin
            if (st_q.cnt == CW'(1)) begin
                st_d.req = 1'b1;
                st_d.cnt = period_i;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rst_req_o = st_q.req;

    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    p_kick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |=> !rst_req_o);

    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.cnt == $past(period_i)));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !rst_req_o);
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              kick,
    output logic              rst_req
);
    localparam int CW = BASE_LOG2 + (1 << PS_W);

    logic            en;
    logic            load;
    logic [PS_W-1:0] ps_nx;
    logic [CW-1:0]   period;

    wdog_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .en_o      (en),
        .ps_nx_o   (ps_nx),
        .load_o    (load),
        .rd_data_o (rd_data)
    );

    wdog_period #(.CW(CW), .BASE(BASE_LOG2), .PS_W(PS_W)) u_period (
        .ps_i     (ps_nx),
        .period_o (period)
    );

    wdog_counter #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .load_i    (load),
        .kick_i    (kick),
        .tick_i    (tick),
        .period_i  (period),
        .rst_req_o (rst_req)
    );
endmodule

// File: tb/sim_wdog_guard.sv
module sim_wdog_guard;
    localparam int CLK_P = 10;
    localparam int BASE  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       kick = 1'b0;
    logic [7:0] rd_data;
    logic       rst_req;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    // reference model state
    bit       m_en;
    int       m_win;
    bit [2:0] m_ps;
    int       m_cnt;
    bit       m_req;

    wdog_guard #(.BASE_LOG2(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .kick(kick), .rst_req(rst_req)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int per(input bit [2:0] ps);
        return 1 << (BASE + ps);
    endfunction

    function automatic logic [7:0] exp_rd();
        return {3'b000, (m_win > 0), m_en, m_ps};
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic model(input bit w, input bit [7:0] d, input bit k, input bit t);
        bit       nen = m_en;
        bit [2:0] nps = w ? d[2:0] : m_ps;
        bit       unl = w && d[4] && d[3];
        bit       ld;
        int       nwin;
        int       ncnt;
        if (w) begin
            if (d[3]) nen = 1'b1;
            else if (m_win > 0) nen = 1'b0;
        end
        ld   = w && ((d[3] && !m_en) || (m_en && nps != m_ps));
        nwin = unl ? 4 : (m_win > 0 ? m_win - 1 : 0);
        m_req = 1'b0;
        ncnt = m_cnt;
        if (!m_en || ld || k) ncnt = per(nps);
        else if (t) begin
            if (m_cnt == 1) begin m_req = 1'b1; ncnt = per(nps); end
            else ncnt = m_cnt - 1;
        end
        m_en = nen; m_win = nwin; m_ps = nps; m_cnt = ncnt;
    endtask

    task automatic step(input bit w, input bit [7:0] d, input bit k, input bit t);
        @(negedge clk);
        wr_en = w; wr_data = d; kick = k; tick = t;
        @(posedge clk);
        #1;
        model(w, d, k, t);
        chk("R1 model rd_data", rd_data, exp_rd());
        chk("R7 model rst_req", rst_req, m_req);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 1'b1);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        m_en = 0; m_win = 0; m_ps = 0; m_cnt = 0; m_req = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset rd_data", rd_data, 8'h00);
        chk("R1 reset rst_req", rst_req, 0);

        // R1 and R2: reserved bits dropped, enable set
        step(1'b1, 8'hE8, 1'b0, 1'b0);
        chk("R2 enable write", rd_data, 8'h08);
        ticks(15);
        chk("R7 no request before period", rst_req, 0);
        ticks(1);
        chk("R7 request at period end", rst_req, 1);
        ticks(1);
        chk("R7 request one cycle", rst_req, 0);

        // R3: plain clear ignored
        step(1'b1, 8'h00, 1'b0, 1'b0);
        chk("R3 enable sticky", rd_data, 8'h08);
        // R6: turn-off without enable opens nothing
        step(1'b1, 8'h10, 1'b0, 1'b0);
        chk("R6 no window", rd_data, 8'h08);

        // R8: kick collides with final tick
        step(1'b0, 8'h00, 1'b1, 1'b0);
        ticks(15);
        step(1'b0, 8'h00, 1'b1, 1'b1);
        chk("R8 kick beats final tick", rst_req, 0);
        ticks(15);
        chk("R8 full period after kick", rst_req, 0);
        ticks(1);
        chk("R8 request after fresh period", rst_req, 1);

        // R9: prescale change reloads, collides with a tick
        ticks(10);
        step(1'b1, 8'h09, 1'b0, 1'b1);
        ticks(31);
        chk("R9 new period not yet out", rst_req, 0);
        ticks(1);
        chk("R9 new period expiry", rst_req, 1);

        // R4 and R5: window closes after four cycles, late clear ignored
        step(1'b1, 8'h19, 1'b0, 1'b0);
        chk("R4 window open", rd_data, 8'h19);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 8'h00, 1'b0, 1'b0);
            chk("R4 window held", rd_data, 8'h19);
        end
        step(1'b0, 8'h00, 1'b0, 1'b0);
        chk("R4 window self-clear", rd_data, 8'h09);
        step(1'b1, 8'h01, 1'b0, 1'b0);
        chk("R5 clear in fifth cycle ignored", rd_data, 8'h09);

        // R5: clear in the fourth cycle works
        step(1'b1, 8'h19, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 1'b0, 1'b0);
        step(1'b1, 8'h01, 1'b0, 1'b0);
        chk("R5 clear in fourth cycle", rd_data, 8'h01);

        // R10: disabled, ticks do nothing
        ticks(200);
        chk("R10 no request while disabled", rst_req, 0);
        chk("R10 still disabled", rd_data, 8'h01);

        // R9: enabling reloads
        step(1'b1, 8'h08, 1'b0, 1'b1);
        ticks(15);
        chk("R9 enable reload not out", rst_req, 0);
        ticks(1);
        chk("R9 enable reload expiry", rst_req, 1);

        // random phase
        for (int n = 0; n < 20000; n++) begin
            bit [7:0] d = 8'($urandom);
            bit       w = ($urandom % 24) == 0;
            bit       k = ($urandom % 80) == 0;
            bit       t = ($urandom % 4) != 0;
            d[2:0] = 3'($urandom % 3);
            step(w, d, k, t);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule